// File: doc/BRIEF.md
# Multi-Standard Video Sync Timing Generator

This block produces the raster timing for a digital video encoder that runs as sync master. It counts samples along each line and lines through each frame, and from those two counters decodes active-low horizontal sync, vertical sync and composite blank, a colour-burst gate and an active-video flag. It also reports the current sample index, the line number within the frame and which field of an interlaced frame is being scanned.

Five sampling standards are supported: 525-line and 625-line systems at 13.5 MHz, both square-pixel rates, and four-times-subcarrier sampling for 525 lines. Each has its own line length and horizontal event positions. Interlaced scanning uses two fields of a whole-plus-half number of lines. Progressive scanning drops the half line, so every field is identical. Vertical events are placed on a half-line grid, where half a line is the line total divided by two. This lets the second interlaced field start in the middle of a line.

The standard and scan selection are read once per frame, on the first sample of the frame. Changes at any other time wait for the next frame.

Top module: `vtg_top`

## Requirements
- R1: The mode code selects the line length in samples: 000 gives 858, 100 gives 864, 001 gives 780, 010 gives 910 and 101 gives 944. The unused codes 011, 110 and 111 behave as 000. `pix_idx` counts from 0 up to the line length minus one, then wraps to 0.
- R2: `hsync_n` is low for samples 0 up to the sync width minus one. The sync width is 63 for 000, 63 for 100, 58 for 001, 67 for 010 and 69 for 101.
- R3: `burst_gate` is high from the burst start sample for the burst length. The start is 71, 75, 65, 75 and 82, and the length is 31, 31, 31, 36 and 34, for codes 000, 100, 001, 010 and 101 in that order. The gate stays low on any half-line inside a vertical sync or equalising zone.
- R4: `active_video` is high from the blanking-end sample up to, but not including, the front-porch sample, on lines outside vertical blanking. Blanking ends at 127, 142, 116, 135 and 155, and the front porch starts at 838, 844, 762, 889 and 922, for codes 000, 100, 001, 010 and 101. `blank_n` is always equal to `active_video`.
- R5: With `interlace_sel`=1 a frame has VL lines: 525 for the 525-line codes (000, 001, 010) and 625 for the 625-line codes (100, 101). With `interlace_sel`=0 a frame has (VL-1)/2 lines. `line_num` counts from 0 within the frame.
- R6: The half-line index is twice `line_num`, plus 1 when `pix_idx` is at least half the line length. A field spans VL half-lines when interlaced and VL-1 half-lines when progressive. The position within the field is that index, less the field span while in the second field. `vsync_n` is low for the first 6 half-lines of a field on 525-line codes and for the first 5 on 625-line codes.
- R7: Vertical blanking covers the field positions from 0 up to the post-sync blank count, plus the last pre-equalising half-lines of the field. The post-sync blank count is 34 for 525-line codes (interlaced or progressive), 45 for interlaced 625-line codes and 44 for progressive 625-line codes. The pre-equalising count is 6 for interlaced 525 lines, 5 for interlaced 625 lines and 4 for either progressive case.
- R8: The sync/equalising zone covers the pre-equalising half-lines at the end of the field, plus field positions below the vsync length plus the post-equalising count. The post-equalising count is 6 for interlaced 525 lines, 4 for progressive 525 lines and 5 for 625 lines (interlaced or progressive).
- R9: `field_id` is 1 while the half-line index is at or beyond the field span of an interlaced frame, and 0 otherwise. It is always 0 in progressive scanning.
- R10: `mode_sel` and `interlace_sel` are captured on the sample where `pix_idx` and `line_num` are both 0, and that sample already follows the new values. Changes on any other sample have no effect until the next such sample.
- R11: While `rst_n` is low: `pix_idx` and `line_num` are 0, `hsync_n` and `vsync_n` are low, `blank_n`, `active_video`, `burst_gate` and `field_id` are low, and the frame-start sample follows the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Sampling standard code |
| interlace_sel | input | 1 | 1 interlaced, 0 progressive |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Composite blank, active low |
| burst_gate | output | 1 | Colour-burst window |
| active_video | output | 1 | Active picture sample |
| pix_idx | output | 10 | Sample index within the line |
| line_num | output | V_W | Line index within the frame |
| field_id | output | 1 | Field of an interlaced frame |

## Verification
The bench runs a chain of complete frames with the field size reduced to a few dozen lines. Every sampling standard is covered, and so are both 625-line and 525-line interlaced frames, both progressive variants and an unused mode code. Every output is compared on every sample against values computed from the tables. This separates errors in a single mode's horizontal constants from errors in the half-line field arithmetic, which shows up only in the odd-length interlaced second field. During each frame the selection inputs are switched to values that differ from the current ones, so any capture outside the frame-start sample breaks the line count or the horizontal positions at once.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int HW = 10;
  localparam int VZW = 6;

  typedef struct packed {
    logic [HW-1:0] total;
    logic [HW-1:0] sync;
    logic [HW-1:0] bst;
    logic [HW-1:0] blen;
    logic [HW-1:0] hbe;
    logic [HW-1:0] fps;
  } htime_t;

  typedef struct packed {
    logic [VZW-1:0] vs;
    logic [VZW-1:0] pre;
    logic [VZW-1:0] post;
    logic [VZW-1:0] vbl;
  } vtime_t;

  typedef struct packed {
    logic [2:0] mode;
    logic       il;
  } cfg_t;

  function automatic logic is_625(input logic [2:0] m);
    return (m == 3'b100) || (m == 3'b101);
  endfunction

  function automatic htime_t h_table(input logic [2:0] m);
    htime_t t;
    case (m)
      3'b100:  t = '{10'd864, 10'd63, 10'd75, 10'd31, 10'd142, 10'd844};
      3'b001:  t = '{10'd780, 10'd58, 10'd65, 10'd31, 10'd116, 10'd762};
      3'b010:  t = '{10'd910, 10'd67, 10'd75, 10'd36, 10'd135, 10'd889};
      3'b101:  t = '{10'd944, 10'd69, 10'd82, 10'd34, 10'd155, 10'd922};
      default: t = '{10'd858, 10'd63, 10'd71, 10'd31, 10'd127, 10'd838};
    endcase
    return t;
  endfunction

  function automatic vtime_t v_table(input logic pal, input logic il);
    vtime_t t;
    case ({pal, il})
      2'b01:   t = '{6'd6, 6'd6, 6'd6, 6'd34};
      2'b00:   t = '{6'd6, 6'd4, 6'd4, 6'd34};
      2'b11:   t = '{6'd5, 6'd5, 6'd5, 6'd45};
      default: t = '{6'd5, 6'd4, 6'd5, 6'd44};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/vtg_cfg.sv
module vtg_cfg
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [2:0] mode_in,
  input  logic       il_in,
  output cfg_t       cfg_eff
);

  cfg_t cfg_q;
  cfg_t cfg_d;
  logic cfg_en;

  always_comb begin
    cfg_d   = '{mode: mode_in, il: il_in};
    cfg_en  = frame_start;
    cfg_eff = frame_start ? cfg_d : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{mode: 3'b000, il: 1'b1};
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  htime_t        ht,
  output logic [HW-1:0] h_q,
  output logic          h_last,
  output logic          second_half,
  output logic          hsync_n,
  output logic          burst_win,
  output logic          h_act
);

  logic [HW-1:0] h_d;

  always_comb begin
    h_last      = (h_q == ht.total - 1'b1);
    h_d         = h_last ? '0 : h_q + 1'b1;
    second_half = (h_q >= (ht.total >> 1));
    hsync_n     = !(h_q < ht.sync);
    burst_win   = (h_q >= ht.bst) && (h_q < ht.bst + ht.blen);
    h_act       = (h_q >= ht.hbe) && (h_q < ht.fps);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
    end else begin
      h_q <= h_d;
    end
  end

  // R1: the sample index only ever steps by one or returns to zero
  a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q != '0) |-> (h_q == $past(h_q) + 1'b1));

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
#(
  parameter int V_W     = 10,
  parameter int VL_NTSC = 525,
  parameter int VL_PAL  = 625
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pal,
  input  logic           il,
  input  vtime_t         vt,
  input  logic           h_last,
  input  logic           second_half,
  output logic [V_W-1:0] ln_q,
  output logic           vsync_n,
  output logic           vblank,
  output logic           eq_zone,
  output logic           field_id
);

  localparam int HL_W = V_W + 1;

  logic [V_W-1:0]  vl;
  logic [V_W-1:0]  flines;
  logic [HL_W-1:0] fh;
  logic [HL_W-1:0] hl;
  logic [HL_W-1:0] fpos;
  logic [HL_W-1:0] tail;
  logic            ln_last;
  logic [V_W-1:0]  ln_d;
  logic            ln_en;

  always_comb begin
    vl       = pal ? V_W'(VL_PAL) : V_W'(VL_NTSC);
    flines   = il ? vl : ((vl - 1'b1) >> 1);
    fh       = il ? HL_W'(vl) : HL_W'(vl - 1'b1);
    hl       = {ln_q, second_half};
    field_id = (hl >= fh);
    fpos     = field_id ? (hl - fh) : hl;
    tail     = fh - HL_W'(vt.pre);
    vsync_n  = !(fpos < HL_W'(vt.vs));
    eq_zone  = (fpos < HL_W'(vt.vs) + HL_W'(vt.post)) || (fpos >= tail);
    vblank   = (fpos < HL_W'(vt.vbl)) || (fpos >= tail);
    ln_last  = (ln_q == flines - 1'b1);
    ln_en    = h_last;
    ln_d     = ln_last ? '0 : ln_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q <= '0;
    end else if (ln_en) begin
      ln_q <= ln_d;
    end
  end

  // R5: the line index moves only after the final sample of a line
  a_r5_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ln_q) |-> $past(h_last));

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int V_W     = 10,
  parameter int VL_NTSC = 525,
  parameter int VL_PAL  = 625
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     mode_sel,
  input  logic           interlace_sel,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           blank_n,
  output logic           burst_gate,
  output logic           active_video,
  output logic [HW-1:0]  pix_idx,
  output logic [V_W-1:0] line_num,
  output logic           field_id
);

  cfg_t           cfg_eff;
  htime_t         ht;
  vtime_t         vt;
  logic           pal;
  logic           frame_start;
  logic [HW-1:0]  h_q;
  logic [V_W-1:0] ln_q;
  logic           h_last;
  logic           second_half;
  logic           burst_win;
  logic           h_act;
  logic           vblank;
  logic           eq_zone;

  always_comb begin
    frame_start = (h_q == '0) && (ln_q == '0);
    pal         = is_625(cfg_eff.mode);
    ht          = h_table(cfg_eff.mode);
    vt          = v_table(pal, cfg_eff.il);
  end

  vtg_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_in     (mode_sel),
    .il_in       (interlace_sel),
    .cfg_eff     (cfg_eff)
  );

  vtg_hcount u_h (
    .clk         (clk),
    .rst_n       (rst_n),
    .ht          (ht),
    .h_q         (h_q),
    .h_last      (h_last),
    .second_half (second_half),
    .hsync_n     (hsync_n),
    .burst_win   (burst_win),
    .h_act       (h_act)
  );

  vtg_vcount #(.V_W(V_W), .VL_NTSC(VL_NTSC), .VL_PAL(VL_PAL)) u_v (
    .clk         (clk),
    .rst_n       (rst_n),
    .pal         (pal),
    .il          (cfg_eff.il),
    .vt          (vt),
    .h_last      (h_last),
    .second_half (second_half),
    .ln_q        (ln_q),
    .vsync_n     (vsync_n),
    .vblank      (vblank),
    .eq_zone     (eq_zone),
    .field_id    (field_id)
  );

  always_comb begin
    burst_gate   = burst_win && !eq_zone;
    active_video = h_act && !vblank;
    blank_n      = active_video;
    pix_idx      = h_q;
    line_num     = ln_q;
  end

  // R2: horizontal sync begins only at the first sample of a line
  a_r2_hsync_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (pix_idx == '0));

  // R3: the burst window never overlaps picture samples
  a_r3_burst_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> !blank_n);

  // R6: vertical sync half-lines are always blanked
  a_r6_vsync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !blank_n);

endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb;

  localparam int VLN = 43;
  localparam int VLP = 51;
  localparam int V_W = 10;

  logic           clk;
  logic           rst_n;
  logic [2:0]     mode_sel;
  logic           interlace_sel;
  logic           hsync_n;
  logic           vsync_n;
  logic           blank_n;
  logic           burst_gate;
  logic           active_video;
  logic [9:0]     pix_idx;
  logic [V_W-1:0] line_num;
  logic           field_id;

  int checks = 0;
  int errors = 0;
  int frame_no = 0;
  int cur_ln = 0;
  int cur_h = 0;
  int cycles = 0;
  bit done = 0;

  vtg_top #(.V_W(V_W), .VL_NTSC(VLN), .VL_PAL(VLP)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .interlace_sel (interlace_sel),
    .hsync_n       (hsync_n),
    .vsync_n       (vsync_n),
    .blank_n       (blank_n),
    .burst_gate    (burst_gate),
    .active_video  (active_video),
    .pix_idx       (pix_idx),
    .line_num      (line_num),
    .field_id      (field_id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s frame %0d line %0d sample %0d: actual %0d expected %0d",
                 req, frame_no, cur_ln, cur_h, got, exp);
    end
  endtask

  task automatic run_frame(input int m, input bit il, input int nm, input bit nil);
    int e, tot, sw, bs, bl, hb, fp, vl, nlines, fh, vs, pre, post, vbl, junk;
    bit pal;
    e = (m == 1 || m == 2 || m == 4 || m == 5) ? m : 0;
    case (e)
      4: begin tot = 864; sw = 63; bs = 75; bl = 31; hb = 142; fp = 844; end
      1: begin tot = 780; sw = 58; bs = 65; bl = 31; hb = 116; fp = 762; end
      2: begin tot = 910; sw = 67; bs = 75; bl = 36; hb = 135; fp = 889; end
      5: begin tot = 944; sw = 69; bs = 82; bl = 34; hb = 155; fp = 922; end
      default: begin tot = 858; sw = 63; bs = 71; bl = 31; hb = 127; fp = 838; end
    endcase
    pal = (e == 4 || e == 5);
    vl = pal ? VLP : VLN;
    nlines = il ? vl : (vl - 1) / 2;
    fh = il ? vl : vl - 1;
    vs = pal ? 5 : 6;
    pre = il ? (pal ? 5 : 6) : 4;
    post = pal ? 5 : (il ? 6 : 4);
    vbl = pal ? (il ? 45 : 44) : 34;
    junk = (e == 4) ? 1 : 4;
    for (int ln = 0; ln < nlines; ln++) begin
      for (int h = 0; h < tot; h++) begin
        int hl, f, fld;
        bit zone, vb;
        cur_ln = ln;
        cur_h = h;
        hl = 2 * ln + ((h >= tot / 2) ? 1 : 0);
        fld = (hl >= fh) ? 1 : 0;
        f = fld ? hl - fh : hl;
        zone = (f < vs + post) || (f >= fh - pre);
        vb = (f < vbl) || (f >= fh - pre);
        if (ln == 0 && h == 0) chk("R10 frame-start line", line_num, 0);
        chk("R1 pix_idx", pix_idx, h);
        chk("R5 line_num", line_num, ln);
        chk("R2 hsync_n", hsync_n, (h < sw) ? 0 : 1);
        chk("R6 vsync_n", vsync_n, (f < vs) ? 0 : 1);
        chk("R3 R8 burst_gate", burst_gate, (h >= bs && h < bs + bl && !zone) ? 1 : 0);
        chk("R4 R7 active_video", active_video, (h >= hb && h < fp && !vb) ? 1 : 0);
        chk("R4 blank_n", blank_n, (h >= hb && h < fp && !vb) ? 1 : 0);
        chk("R9 field_id", field_id, fld);
        if (ln == 2 && h == 0) begin
          // R10: mid-frame changes must be ignored
          mode_sel = 3'(junk);
          interlace_sel = !il;
        end
        if (ln == nlines - 1 && h == 0) begin
          mode_sel = 3'(nm);
          interlace_sel = nil;
        end
        @(negedge clk);
      end
    end
    frame_no++;
  endtask

  initial begin
    rst_n = 1'b0;
    mode_sel = 3'b000;
    interlace_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 pix_idx", pix_idx, 0);
    chk("R11 line_num", line_num, 0);
    chk("R11 hsync_n", hsync_n, 0);
    chk("R11 vsync_n", vsync_n, 0);
    chk("R11 blank_n", blank_n, 0);
    chk("R11 active_video", active_video, 0);
    chk("R11 burst_gate", burst_gate, 0);
    chk("R11 field_id", field_id, 0);
    rst_n = 1'b1;
    run_frame(0, 1, 4, 1);
    run_frame(4, 1, 1, 1);
    run_frame(1, 1, 2, 0);
    run_frame(2, 0, 5, 0);
    run_frame(5, 0, 3, 0);
    run_frame(3, 0, 3, 0);
    done = 1;
  end

  initial begin
    wait (done || cycles >= 199000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule